// File: doc/BRIEF.md
# Byte-Lane Dual-Port RAM with Write Inhibit

A synchronous true dual-port memory of 2048 words by 16 bits. A left and a right port each carry an address, a chip select, an output enable, one write strobe per byte lane and a busy input. The busy input is active low and blocks writes from its own port. All controls are sampled on the rising clock edge. Read data and a valid flag for each lane appear one cycle after the access.

Each byte lane of an access is decoded on its own. In a single cycle a port can write one byte of a word and read back the other byte of the same word. A lane that drives nothing is reported as high-impedance: its valid flag is low and its data lane reads zero. A port is deselected when its chip select is high, and a lane is not driven when it is being written or when output enable is high.

The busy input is meant to be driven by an external address-contention arbiter. It can also be tied high for normal operation, or held low to write-protect a port. Either way it leaves reads untouched.

Top module: `lane_dpram`

## Requirements
- R1: The array holds 2048 words of 16 bits, selected by an 11-bit address on each port. A word written through one port is read back unchanged through either port.
- R2: Write strobes are active low and work per lane. we_ni[0] controls bits 7:0 and we_ni[1] controls bits 15:8. Only the lanes whose strobe is low change.
- R3: While a port's chip select is high, that port changes no memory and both of its valid flags are low in the next cycle, whatever its other controls are.
- R4: With chip select low, a lane whose strobe is high and whose output enable is low gives valid=1 and the stored byte one cycle later. If output enable is high, or the lane's strobe is low, that lane gives valid=0.
- R5: A lane whose valid flag is low reads as zero on its data bits.
- R6: When a port writes one lane with output enable low, the same access returns the stored byte of the other lane, valid one cycle later.
- R7: A low busy input blocks every write from that port and leaves memory unchanged. Reads on that port still proceed as in R4.
- R8: If both ports write the same lane of the same address in one cycle and neither is blocked, the left port's byte is stored. Lanes written by only one port take that port's byte.
- R9: A read of a location that the other port writes in the same cycle returns the contents from before the write.
- R10: During and after reset, every valid flag and every data bit is zero until the first access completes.
- R11: The two ports work independently. Concurrent accesses at different addresses each behave as if the port were alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_cs_ni | input | 1 | Left chip select, active low |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_we_ni | input | 2 | Left per-lane write strobes, active low |
| l_busy_ni | input | 1 | Left write inhibit, active low |
| l_addr_i | input | 11 | Left word address |
| l_wdata_i | input | 16 | Left write data |
| l_rdata_o | output | 16 | Left read data, zero on undriven lanes |
| l_rvalid_o | output | 2 | Left per-lane read valid |
| r_cs_ni | input | 1 | Right chip select, active low |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_we_ni | input | 2 | Right per-lane write strobes, active low |
| r_busy_ni | input | 1 | Right write inhibit, active low |
| r_addr_i | input | 11 | Right word address |
| r_wdata_i | input | 16 | Right write data |
| r_rdata_o | output | 16 | Right read data, zero on undriven lanes |
| r_rvalid_o | output | 2 | Right per-lane read valid |

## Verification
The hardest cases to reach are the same-cycle collisions: both ports writing one lane of one word, and one port reading a word that the other port is writing. These only show up when both ports name the same address on the same edge with chosen strobe patterns. Directed cycles set up each collision on purpose. A long random phase then confines both addresses to sixteen words and draws busy and strobe patterns on every cycle, so overlaps of every kind recur many times. A behavioural model compares both ports on every cycle.

// File: rtl/lane_dpram_pkg.sv
package lane_dpram_pkg;
  localparam int unsigned DEF_ADDR_W = 11;
  localparam int unsigned DEF_LANE_W = 8;
  localparam int unsigned DEF_LANES  = 2;

  typedef enum logic [1:0] {
    LANE_IDLE    = 2'd0,
    LANE_READ    = 2'd1,
    LANE_WRITE   = 2'd2,
    LANE_BLOCKED = 2'd3
  } lane_op_e;
endpackage

// File: rtl/lane_dpram_ctrl.sv
module lane_dpram_ctrl
  import lane_dpram_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES
) (
  input  logic                   cs_ni,
  input  logic                   oe_ni,
  input  logic [LANES-1:0]       we_ni,
  input  logic                   busy_ni,
  output lane_op_e [LANES-1:0]   op_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_comb begin
      if (cs_ni)            op_o[k] = LANE_IDLE;
      else if (!we_ni[k])   op_o[k] = busy_ni ? LANE_WRITE : LANE_BLOCKED;
      else if (!oe_ni)      op_o[k] = LANE_READ;
      else                  op_o[k] = LANE_IDLE;
    end
  end
endmodule

// File: rtl/lane_dpram_mem.sv
module lane_dpram_mem
  import lane_dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter int unsigned LANES  = DEF_LANES,
  localparam int unsigned DEPTH  = 1 << ADDR_W,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic [LANES-1:0]  l_wr_i,
  input  logic [LANES-1:0]  l_rd_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic [LANES-1:0]  r_wr_i,
  input  logic [LANES-1:0]  r_rd_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] l_q, r_q;

    // right first so a left write to the same cell lands last
    always_ff @(posedge clk_i) begin
      if (r_wr_i[k]) mem_q[r_addr_i] <= r_wdata_i[k*LANE_W +: LANE_W];
      if (l_wr_i[k]) mem_q[l_addr_i] <= l_wdata_i[k*LANE_W +: LANE_W];
    end

    // read-first: nonblocking update leaves old contents visible
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        l_q <= '0;
        r_q <= '0;
      end else begin
        l_q <= l_rd_i[k] ? mem_q[l_addr_i] : '0;
        r_q <= r_rd_i[k] ? mem_q[r_addr_i] : '0;
      end
    end

    assign l_rdata_o[k*LANE_W +: LANE_W] = l_q;
    assign r_rdata_o[k*LANE_W +: LANE_W] = r_q;
  end
endmodule

// File: rtl/lane_dpram.sv
module lane_dpram
  import lane_dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned LANE_W = DEF_LANE_W,
  parameter int unsigned LANES  = DEF_LANES,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_cs_ni,
  input  logic              l_oe_ni,
  input  logic [LANES-1:0]  l_we_ni,
  input  logic              l_busy_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic [LANES-1:0]  l_rvalid_o,
  input  logic              r_cs_ni,
  input  logic              r_oe_ni,
  input  logic [LANES-1:0]  r_we_ni,
  input  logic              r_busy_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic [LANES-1:0]  r_rvalid_o
);
  lane_op_e [LANES-1:0] l_op, r_op;
  logic [LANES-1:0] l_wr, l_rd, r_wr, r_rd;
  logic [LANES-1:0] l_vld_q, r_vld_q;

  lane_dpram_ctrl #(.LANES(LANES)) i_l_ctrl (
    .cs_ni(l_cs_ni), .oe_ni(l_oe_ni), .we_ni(l_we_ni),
    .busy_ni(l_busy_ni), .op_o(l_op)
  );

  lane_dpram_ctrl #(.LANES(LANES)) i_r_ctrl (
    .cs_ni(r_cs_ni), .oe_ni(r_oe_ni), .we_ni(r_we_ni),
    .busy_ni(r_busy_ni), .op_o(r_op)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_dec
    assign l_wr[k] = (l_op[k] == LANE_WRITE);
    assign l_rd[k] = (l_op[k] == LANE_READ);
    assign r_wr[k] = (r_op[k] == LANE_WRITE);
    assign r_rd[k] = (r_op[k] == LANE_READ);
  end

  lane_dpram_mem #(
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
  ) i_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .l_addr_i  (l_addr_i),
    .l_wdata_i (l_wdata_i),
    .l_wr_i    (l_wr),
    .l_rd_i    (l_rd),
    .l_rdata_o (l_rdata_o),
    .r_addr_i  (r_addr_i),
    .r_wdata_i (r_wdata_i),
    .r_wr_i    (r_wr),
    .r_rd_i    (r_rd),
    .r_rdata_o (r_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_vld_q <= '0;
      r_vld_q <= '0;
    end else begin
      l_vld_q <= l_rd;
      r_vld_q <= r_rd;
    end
  end

  assign l_rvalid_o = l_vld_q;
  assign r_rvalid_o = r_vld_q;
endmodule

// File: rtl/lane_dpram_chk.sv
module lane_dpram_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_cs_ni,
  input logic              l_oe_ni,
  input logic [LANES-1:0]  l_we_ni,
  input logic              l_busy_ni,
  input logic [DATA_W-1:0] l_rdata_o,
  input logic [LANES-1:0]  l_rvalid_o,
  input logic              r_cs_ni,
  input logic              r_oe_ni,
  input logic [LANES-1:0]  r_we_ni,
  input logic              r_busy_ni,
  input logic [DATA_W-1:0] r_rdata_o,
  input logic [LANES-1:0]  r_rvalid_o
);
  AST_L_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_cs_ni |=> (l_rvalid_o == '0)); // R3
  AST_R_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_cs_ni |=> (r_rvalid_o == '0)); // R3

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    AST_L_WLANE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!l_cs_ni && !l_we_ni[k]) |=> !l_rvalid_o[k]); // R4
    AST_R_WLANE_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!r_cs_ni && !r_we_ni[k]) |=> !r_rvalid_o[k]); // R4
    AST_L_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!l_cs_ni && l_oe_ni) |=> !l_rvalid_o[k]); // R4
    AST_R_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!r_cs_ni && r_oe_ni) |=> !r_rvalid_o[k]); // R4
    AST_L_BUSY_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!l_cs_ni && !l_busy_ni && l_we_ni[k] && !l_oe_ni) |=> l_rvalid_o[k]); // R7
    AST_R_BUSY_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!r_cs_ni && !r_busy_ni && r_we_ni[k] && !r_oe_ni) |=> r_rvalid_o[k]); // R7
    AST_L_DARK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !l_rvalid_o[k] |-> (l_rdata_o[k*LANE_W +: LANE_W] == '0)); // R5
    AST_R_DARK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !r_rvalid_o[k] |-> (r_rdata_o[k*LANE_W +: LANE_W] == '0)); // R5
  end
endmodule

bind lane_dpram lane_dpram_chk #(
  .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_cs_ni(l_cs_ni), .l_oe_ni(l_oe_ni), .l_we_ni(l_we_ni), .l_busy_ni(l_busy_ni),
  .l_rdata_o(l_rdata_o), .l_rvalid_o(l_rvalid_o),
  .r_cs_ni(r_cs_ni), .r_oe_ni(r_oe_ni), .r_we_ni(r_we_ni), .r_busy_ni(r_busy_ni),
  .r_rdata_o(r_rdata_o), .r_rvalid_o(r_rvalid_o)
);

// File: tb/test_lane_dpram.sv
module test_lane_dpram;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 2048;

  typedef struct packed {
    logic        cs_n;
    logic        oe_n;
    logic [1:0]  we_n;
    logic        busy_n;
    logic [10:0] addr;
    logic [15:0] wdata;
  } pin_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  pin_t lp, rp;
  logic [15:0] l_rdata, r_rdata;
  logic [1:0]  l_rvalid, r_rvalid;

  logic [15:0] mem_m [DEPTH];
  logic [15:0] exp_ld = '0, exp_rd = '0;
  logic [1:0]  exp_lv = '0, exp_rv = '0;
  string       prev_tag = "R10";
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_dpram i_lane_dpram (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_cs_ni(lp.cs_n), .l_oe_ni(lp.oe_n), .l_we_ni(lp.we_n), .l_busy_ni(lp.busy_n),
    .l_addr_i(lp.addr), .l_wdata_i(lp.wdata), .l_rdata_o(l_rdata), .l_rvalid_o(l_rvalid),
    .r_cs_ni(rp.cs_n), .r_oe_ni(rp.oe_n), .r_we_ni(rp.we_n), .r_busy_ni(rp.busy_n),
    .r_addr_i(rp.addr), .r_wdata_i(rp.wdata), .r_rdata_o(r_rdata), .r_rvalid_o(r_rvalid)
  );

  function automatic pin_t p_acc(logic cs, logic oe, logic [1:0] we, logic busy,
                                 logic [10:0] a, logic [15:0] d);
    pin_t p;
    p.cs_n = cs; p.oe_n = oe; p.we_n = we; p.busy_n = busy; p.addr = a; p.wdata = d;
    return p;
  endfunction

  function automatic pin_t p_idle();
    return p_acc(1'b1, 1'b1, 2'b11, 1'b1, '0, '0);
  endfunction

  function automatic pin_t p_rd(logic [10:0] a);
    return p_acc(1'b0, 1'b0, 2'b11, 1'b1, a, '0);
  endfunction

  function automatic logic [15:0] pat(int a);
    return 16'(a * 37) ^ 16'h5a3c;
  endfunction

  // model: reads see old contents, right writes then left writes
  task automatic model(pin_t l, pin_t r);
    for (int k = 0; k < 2; k++) begin
      exp_lv[k] = !l.cs_n && l.we_n[k] && !l.oe_n;
      exp_rv[k] = !r.cs_n && r.we_n[k] && !r.oe_n;
      exp_ld[k*8 +: 8] = exp_lv[k] ? mem_m[l.addr][k*8 +: 8] : 8'h00;
      exp_rd[k*8 +: 8] = exp_rv[k] ? mem_m[r.addr][k*8 +: 8] : 8'h00;
    end
    for (int k = 0; k < 2; k++) begin
      if (!r.cs_n && !r.we_n[k] && r.busy_n) mem_m[r.addr][k*8 +: 8] = r.wdata[k*8 +: 8];
      if (!l.cs_n && !l.we_n[k] && l.busy_n) mem_m[l.addr][k*8 +: 8] = l.wdata[k*8 +: 8];
    end
  endtask

  task automatic compare();
    checks++;
    if (l_rdata !== exp_ld || l_rvalid !== exp_lv) begin
      errors++;
      $display("FAIL %s left: rdata=%h rvalid=%b expected rdata=%h rvalid=%b",
               prev_tag, l_rdata, l_rvalid, exp_ld, exp_lv);
    end
    checks++;
    if (r_rdata !== exp_rd || r_rvalid !== exp_rv) begin
      errors++;
      $display("FAIL %s right: rdata=%h rvalid=%b expected rdata=%h rvalid=%b",
               prev_tag, r_rdata, r_rvalid, exp_rd, exp_rv);
    end
  endtask

  task automatic cyc(string tag, pin_t l, pin_t r);
    @(negedge clk);
    compare();
    lp = l;
    rp = r;
    model(l, r);
    prev_tag = tag;
  endtask

  initial begin
    lp = p_idle();
    rp = p_idle();
    repeat (3) @(negedge clk);
    compare(); // R10: reset state
    rst_ni = 1'b1;
    cyc("R10", p_idle(), p_idle());
    cyc("R10", p_idle(), p_idle());

    // R1: fill the whole array through the left port
    for (int a = 0; a < DEPTH; a++)
      cyc("R1", p_acc(1'b0, 1'b1, 2'b00, 1'b1, 11'(a), pat(a)), p_idle());
    // R1 / R11: both ports read different words concurrently
    for (int a = 0; a < 64; a++)
      cyc("R11", p_rd(11'(a)), p_rd(11'(DEPTH - 1 - a)));
    cyc("R1", p_idle(), p_rd(11'd2047));

    // R2: lower-only and upper-only writes
    cyc("R2", p_acc(1'b0, 1'b1, 2'b10, 1'b1, 11'd5, 16'hbeef), p_idle());
    cyc("R2", p_rd(11'd5), p_acc(1'b0, 1'b1, 2'b01, 1'b1, 11'd5, 16'h1234));
    cyc("R2", p_rd(11'd5), p_idle());
    // R6: write one lane, read the other in the same access
    cyc("R6", p_acc(1'b0, 1'b0, 2'b01, 1'b1, 11'd6, 16'hc3aa), p_idle());
    cyc("R6", p_idle(), p_acc(1'b0, 1'b0, 2'b10, 1'b1, 11'd6, 16'h0077));
    cyc("R6", p_rd(11'd6), p_idle());

    // R3: deselected port ignores strobes
    cyc("R3", p_acc(1'b1, 1'b0, 2'b00, 1'b1, 11'd9, 16'hdead), p_acc(1'b1, 1'b0, 2'b00, 1'b1, 11'd9, 16'hf00d));
    cyc("R3", p_rd(11'd9), p_rd(11'd9));

    // R4 / R5: output enable high gives dark lanes
    cyc("R4", p_acc(1'b0, 1'b1, 2'b11, 1'b1, 11'd9, '0), p_acc(1'b0, 1'b1, 2'b11, 1'b1, 11'd3, '0));
    cyc("R5", p_idle(), p_idle());

    // R7: busy blocks writes, reads still run
    cyc("R7", p_acc(1'b0, 1'b0, 2'b00, 1'b0, 11'd10, 16'h5555), p_acc(1'b0, 1'b0, 2'b10, 1'b0, 11'd11, 16'h6666));
    cyc("R7", p_acc(1'b0, 1'b0, 2'b01, 1'b0, 11'd10, 16'h7777), p_rd(11'd11));
    cyc("R7", p_rd(11'd10), p_rd(11'd11));

    // R8: same word, same lane, both write
    cyc("R8", p_acc(1'b0, 1'b1, 2'b00, 1'b1, 11'd20, 16'h1111), p_acc(1'b0, 1'b1, 2'b00, 1'b1, 11'd20, 16'h2222));
    cyc("R8", p_acc(1'b0, 1'b1, 2'b10, 1'b1, 11'd21, 16'h3344), p_acc(1'b0, 1'b1, 2'b01, 1'b1, 11'd21, 16'h5566));
    cyc("R8", p_rd(11'd20), p_rd(11'd21));
    cyc("R8", p_acc(1'b0, 1'b1, 2'b00, 1'b0, 11'd22, 16'h9999), p_acc(1'b0, 1'b1, 2'b00, 1'b1, 11'd22, 16'haaaa));
    cyc("R8", p_rd(11'd22), p_idle());

    // R9: read of a word the other port writes in the same cycle
    cyc("R9", p_acc(1'b0, 1'b1, 2'b00, 1'b1, 11'd30, 16'h0f0f), p_rd(11'd30));
    cyc("R9", p_rd(11'd31), p_acc(1'b0, 1'b1, 2'b00, 1'b1, 11'd31, 16'hf0f0));
    cyc("R9", p_rd(11'd31), p_rd(11'd30));

    // R11: random traffic on a small address window
    for (int i = 0; i < 3000; i++) begin
      pin_t l, r;
      l = p_acc(1'($urandom_range(0, 4) == 0), 1'($urandom), 2'($urandom), 1'($urandom_range(0, 3) != 0),
                11'($urandom_range(0, 15)), 16'($urandom));
      r = p_acc(1'($urandom_range(0, 4) == 0), 1'($urandom), 2'($urandom), 1'($urandom_range(0, 3) != 0),
                11'($urandom_range(0, 15)), 16'($urandom));
      cyc("R11", l, r);
    end
    cyc("R11", p_idle(), p_idle());
    cyc("R11", p_idle(), p_idle());

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule